// File: doc/BRIEF.md
# Thread Block Barrier Unit

The barrier unit holds back the warps of a thread block at a synchronization instruction until every warp of that block has reached it. Each time a warp executes the barrier, the issue logic sends a one-cycle arrive strobe carrying the warp number and the number of the block slot the warp belongs to. The unit raises that warp's bit in a stall mask that goes to the warp scheduler. When the last outstanding warp of the block arrives, every stalled warp of that block is released in the same cycle. The arrival count clears at that point, so the next barrier in the same block starts from zero.

Several blocks can be resident at once. Each block slot has its own arrival counter and its own expected warp count. The expected count is latched when the block is launched and is derived from the block's thread count: the thread count divided by the warp width, rounded up. A warp that arrives again while it is already stalled does not count a second time. The unit reports that event on a one-cycle error flag.

Top module: `bar_unit`

## Requirements
- R1: After reset, `stall_o`, `release_vld_o` and `dup_err_o` are all zero.
- R2: An accepted arrive that does not complete its block sets `stall_o[warp]` at the next clock edge, and no other stall bit changes.
- R3: A launch of block slot b with thread count t latches the expected warp count ceil(t/32) and zeroes the slot's arrival counter. The block is released on the arrive that brings the counter to that value.
- R4: On release, every stall bit of warps waiting on that block clears at the same edge. The last warp to arrive is never stalled. `release_vld_o` is high for one cycle with `release_blk_o` equal to the block number.
- R5: A block of 1 to 32 threads (one warp) is released by its single arrive, and no stall bit is set.
- R6: A block of 512 threads needs 16 arrivals. The first 15 arrivals stall their warps and the 16th releases all of them.
- R7: A release of one block leaves the stall bits and the arrival count of every other block unchanged.
- R8: The arrival counter clears at the release edge. A new barrier round in the same block may start in the very next cycle, and it again needs the full warp count.
- R9: An arrive from a warp whose stall bit is already set is ignored: the stall mask and the block's count do not change. `dup_err_o` is high for one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_vld_i | input | 1 | Block launch strobe |
| launch_blk_i | input | BLK_W | Slot of the launched block |
| launch_thr_i | input | THR_W | Thread count of the launched block (1..MAX_THREADS) |
| arrive_vld_i | input | 1 | Barrier arrive strobe |
| arrive_warp_i | input | WARP_W | Arriving warp number |
| arrive_blk_i | input | BLK_W | Block slot of the arriving warp |
| stall_o | output | NUM_WARPS | Per-warp issue stall mask to the scheduler |
| release_vld_o | output | 1 | One-cycle pulse when a block is released |
| release_blk_o | output | BLK_W | Block released with the pulse |
| dup_err_o | output | 1 | One-cycle pulse after an ignored repeated arrive |

## Verification
The hardest condition to reach is two blocks with partial arrival counts at the same time, where one block completes while the other still has warps stalled. The bench builds this by interleaving arrivals from two blocks before it finishes either one. It then checks that the stall mask keeps exactly the other block's warps. A second hard case is a repeated arrive that lands just before the real last arrival. The bench sends it mid-round and then confirms that the round still waits for its true final warp. The full 16-warp block and back-to-back barrier rounds with no idle cycle are driven directly.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int unsigned DEF_NUM_WARPS   = 32;
  localparam int unsigned DEF_NUM_BLOCKS  = 8;
  localparam int unsigned DEF_WARP_SIZE   = 32;
  localparam int unsigned DEF_MAX_THREADS = 512;

  // ceil(threads / warp_size)
  function automatic int unsigned warps_needed(int unsigned threads, int unsigned warp_size);
    return (threads + warp_size - 1) / warp_size;
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot #(
  parameter int unsigned WARP_SIZE = bar_pkg::DEF_WARP_SIZE,
  parameter int unsigned THR_W     = 10,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [THR_W-1:0] launch_thr_i,
  input  logic             arrive_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, exp_q, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit_o   = arrive_i && !launch_i && (cnt_inc == exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (launch_i) begin
      cnt_q <= '0;
      exp_q <= CNT_W'(bar_pkg::warps_needed(32'(launch_thr_i), WARP_SIZE));
    end else if (hit_o) begin
      cnt_q <= '0;
    end else if (arrive_i) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/bar_warp.sv
module bar_warp #(
  parameter int unsigned BLK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             rel_i,
  input  logic [BLK_W-1:0] rel_blk_i,
  output logic             wait_o
);
  logic             wait_q;
  logic [BLK_W-1:0] blk_q;

  assign wait_o = wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      blk_q  <= '0;
    end else if (wait_q && rel_i && blk_q == rel_blk_i) begin
      wait_q <= 1'b0;
    end else if (set_i) begin
      wait_q <= 1'b1;
      blk_q  <= blk_i;
    end
  end
endmodule

// File: rtl/bar_unit.sv
module bar_unit #(
  parameter int unsigned NUM_WARPS   = bar_pkg::DEF_NUM_WARPS,
  parameter int unsigned NUM_BLOCKS  = bar_pkg::DEF_NUM_BLOCKS,
  parameter int unsigned WARP_SIZE   = bar_pkg::DEF_WARP_SIZE,
  parameter int unsigned MAX_THREADS = bar_pkg::DEF_MAX_THREADS,
  localparam int unsigned WARP_W     = $clog2(NUM_WARPS),
  localparam int unsigned BLK_W      = $clog2(NUM_BLOCKS),
  localparam int unsigned THR_W      = $clog2(MAX_THREADS) + 1,
  localparam int unsigned CNT_W      = $clog2(MAX_THREADS / WARP_SIZE) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 launch_vld_i,
  input  logic [BLK_W-1:0]     launch_blk_i,
  input  logic [THR_W-1:0]     launch_thr_i,
  input  logic                 arrive_vld_i,
  input  logic [WARP_W-1:0]    arrive_warp_i,
  input  logic [BLK_W-1:0]     arrive_blk_i,
  output logic [NUM_WARPS-1:0] stall_o,
  output logic                 release_vld_o,
  output logic [BLK_W-1:0]     release_blk_o,
  output logic                 dup_err_o
);
  logic [NUM_WARPS-1:0]  waiting;
  logic [NUM_BLOCKS-1:0] hit;
  logic                  dup, accept, rel_now;

  assign dup     = arrive_vld_i && waiting[arrive_warp_i];
  assign accept  = arrive_vld_i && !dup;
  assign rel_now = |hit;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_slot
    bar_slot #(.WARP_SIZE(WARP_SIZE), .THR_W(THR_W), .CNT_W(CNT_W)) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .launch_i     (launch_vld_i && launch_blk_i == BLK_W'(b)),
      .launch_thr_i (launch_thr_i),
      .arrive_i     (accept && arrive_blk_i == BLK_W'(b)),
      .hit_o        (hit[b])
    );
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    bar_warp #(.BLK_W(BLK_W)) i_warp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (accept && !rel_now && arrive_warp_i == WARP_W'(w)),
      .blk_i     (arrive_blk_i),
      .rel_i     (rel_now),
      .rel_blk_i (arrive_blk_i),
      .wait_o    (waiting[w])
    );
  end

  assign stall_o = waiting;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      release_vld_o <= 1'b0;
      release_blk_o <= '0;
      dup_err_o     <= 1'b0;
    end else begin
      release_vld_o <= rel_now;
      release_blk_o <= rel_now ? arrive_blk_i : release_blk_o;
      dup_err_o     <= dup;
    end
  end
endmodule

// File: rtl/bar_unit_chk.sv
module bar_unit_chk #(
  parameter int unsigned NUM_WARPS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 arrive_vld_i,
  input logic [NUM_WARPS-1:0] stall_o,
  input logic                 release_vld_o,
  input logic                 dup_err_o
);
  // R9
  dup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_err_o |-> stall_o == $past(stall_o));

  // R2
  stall_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(arrive_vld_i) |-> (stall_o & ~$past(stall_o)) == '0);

  // R2
  one_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stall_o & ~$past(stall_o)) <= 1);

  // R4
  rel_nogrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_vld_o |-> (stall_o & ~$past(stall_o)) == '0);

  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(release_vld_o && dup_err_o));

  // R4
  rel_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_vld_o |=> !release_vld_o || $past(arrive_vld_i));
endmodule

bind bar_unit bar_unit_chk #(.NUM_WARPS(NUM_WARPS)) i_bar_unit_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .arrive_vld_i  (arrive_vld_i),
  .stall_o       (stall_o),
  .release_vld_o (release_vld_o),
  .dup_err_o     (dup_err_o)
);

// File: tb/test_bar_unit.sv
`timescale 1ns/1ps
module test_bar_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_vld = 1'b0;
  logic [2:0]  launch_blk = '0;
  logic [9:0]  launch_thr = '0;
  logic        arrive_vld = 1'b0;
  logic [4:0]  arrive_warp = '0;
  logic [2:0]  arrive_blk = '0;
  logic [31:0] stall;
  logic        rel_vld;
  logic [2:0]  rel_blk;
  logic        dup_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bar_unit i_bar_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .launch_vld_i(launch_vld), .launch_blk_i(launch_blk), .launch_thr_i(launch_thr),
    .arrive_vld_i(arrive_vld), .arrive_warp_i(arrive_warp), .arrive_blk_i(arrive_blk),
    .stall_o(stall), .release_vld_o(rel_vld), .release_blk_o(rel_blk), .dup_err_o(dup_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(int blk, int thr);
    @(negedge clk);
    launch_vld = 1'b1; launch_blk = 3'(blk); launch_thr = 10'(thr);
    @(posedge clk); @(negedge clk);
    launch_vld = 1'b0;
  endtask

  // drives one arrive; returns at the negedge after the capturing edge
  task automatic arrive(int warp, int blk);
    arrive_vld = 1'b1; arrive_warp = 5'(warp); arrive_blk = 3'(blk);
    @(posedge clk); @(negedge clk);
    arrive_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stall", 64'(stall), 0);
    chk("R1 release", 64'(rel_vld), 0);
    chk("R1 dup", 64'(dup_err), 0);
  endtask

  task automatic t_basic;
    launch(0, 70);
    arrive(0, 0);
    chk("R2 stall w0", 64'(stall), 64'h1);
    chk("R3 no early release", 64'(rel_vld), 0);
    arrive(1, 0);
    chk("R2 stall w1", 64'(stall), 64'h3);
    arrive(2, 0);
    chk("R4 stall cleared", 64'(stall), 0);
    chk("R3 release", 64'(rel_vld), 1);
    chk("R4 release blk", 64'(rel_blk), 0);
    @(negedge clk);
    chk("R4 one-cycle pulse", 64'(rel_vld), 0);
  endtask

  task automatic t_single;
    launch(1, 20);
    @(negedge clk);
    arrive(5, 1);
    chk("R5 no stall", 64'(stall), 0);
    chk("R5 release", 64'(rel_vld), 1);
    chk("R5 release blk", 64'(rel_blk), 1);
  endtask

  task automatic t_full;
    logic [31:0] m = '0;
    launch(2, 512);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      arrive(8 + i, 2);
      if (i < 15) begin
        m[8 + i] = 1'b1;
        chk("R6 partial stall", 64'(stall), 64'(m));
        chk("R6 no release", 64'(rel_vld), 0);
      end else begin
        chk("R6 all released", 64'(stall), 0);
        chk("R6 release", 64'(rel_vld), 1);
        chk("R6 release blk", 64'(rel_blk), 2);
      end
    end
  endtask

  task automatic t_indep;
    launch(3, 64);
    launch(4, 96);
    @(negedge clk);
    arrive(24, 3);
    arrive(26, 4);
    arrive(27, 4);
    chk("R7 mixed stall", 64'(stall), 64'h0d00_0000);
    arrive(25, 3);
    chk("R7 other block kept", 64'(stall), 64'h0c00_0000);
    chk("R7 release blk3", 64'(rel_blk), 3);
    arrive(28, 4);
    chk("R7 blk4 released", 64'(stall), 0);
    chk("R7 release blk4", 64'(rel_blk), 4);
  endtask

  task automatic t_reuse;
    @(negedge clk);
    arrive(0, 0);
    arrive(1, 0);
    arrive(2, 0);
    chk("R8 round1 release", 64'(rel_vld), 1);
    arrive(0, 0);
    chk("R8 round2 restart", 64'(stall), 64'h1);
    chk("R8 no instant release", 64'(rel_vld), 0);
    arrive(1, 0);
    arrive(2, 0);
    chk("R8 round2 release", 64'(rel_vld), 1);
    chk("R8 round2 clear", 64'(stall), 0);
  endtask

  task automatic t_dup;
    launch(5, 96);
    @(negedge clk);
    arrive(29, 5);
    arrive(29, 5);
    chk("R9 dup flag", 64'(dup_err), 1);
    chk("R9 stall unchanged", 64'(stall), 64'h2000_0000);
    arrive(30, 5);
    chk("R9 dup not counted", 64'(rel_vld), 0);
    chk("R9 dup flag clears", 64'(dup_err), 0);
    chk("R9 stall w30", 64'(stall), 64'h6000_0000);
    arrive(31, 5);
    chk("R9 release", 64'(rel_vld), 1);
    chk("R9 cleared", 64'(stall), 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_full();
    t_indep();
    t_reuse();
    t_dup();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule